// File: doc/BRIEF.md
# Transmit Descriptor DMA Engine

This block feeds a MAC transmitter from memory. Software builds a ring of four-word descriptors, each pointing at one frame buffer. It writes the ring's base address into a register and then sets a request bit. The engine then walks the ring on its own. For each owned descriptor it reads the buffer through a simple memory read/write master and hands the bytes to the MAC as 32-bit beats on a valid/ready stream. It then gives the descriptor back to software by clearing its ownership flag in memory, and moves on to the next descriptor.

Software cannot stop a running transfer. The engine stops only when it reads a descriptor that software has not handed over. At that point it drops the request bit itself. A software reset returns the engine to a known idle state. The reset runs over a fixed window of clocks and keeps the two list-base registers unchanged.

Stream rules: a beat moves when `tx_valid` and `tx_ready` are both high on a clock edge. While `tx_ready` is low, the engine holds `tx_valid`, `tx_data`, `tx_keep` and `tx_last` steady. The engine never withdraws a beat it has offered, except when a software reset starts. Byte 0 of a beat is `tx_data[7:0]`.

Top module: `txd_engine`

## Requirements
- R1: Writing 1 to bit 0 of the request register (index 1) while that bit reads 0 sets it. It also loads the descriptor pointer from the transmit list base (index 2), and the first memory read then goes to that base address.
- R2: A descriptor is four 32-bit words at a 16-byte-aligned address. In word 0, bit 31 marks it as owned by the engine, bit 30 marks it as last in the ring, and bits 15:0 give the frame length in bytes. Word 1 holds the word-aligned buffer address. For an owned descriptor of length L, the engine sends ceil(L/4) beats taken from consecutive buffer words. On every beat but the final one, `tx_keep` is 4'b1111. On the final beat, `tx_last` is 1 and `tx_keep` has its low (L mod 4) bits set, or all four bits when L mod 4 is 0.
- R3: Writing 0 to the request bit, or writing 1 while it is already set, changes nothing. A frame in progress completes in full.
- R4: After the final beat of a frame, the engine writes word 0 back to the descriptor address with bit 31 cleared and all other bits unchanged. The pointer then moves to the current address plus 16, or to the list base when bit 30 was set.
- R5: After a write-back, the engine fetches the next descriptor immediately. If that descriptor is owned, it is sent without software action. If it is not owned, the request bit clears and no further memory access follows.
- R6: A descriptor of length 0 produces no stream beat. It is still written back and the engine still advances past it.
- R7: While `tx_valid` is high and `tx_ready` is low, the beat stays offered and unchanged. The delivered byte sequence is the same for any back-pressure pattern.
- R8: Bits 31:1 of the request register read as 0. Writing 0xFFFF_FFFE there leaves the register at 0 and starts nothing.
- R9: Writing 1 to bit 0 of the control register (index 0) starts a soft reset. `srst_busy`, which also reads back as bit 0 of index 0, is high for exactly 16 cycles. During that window the engine makes no memory request, offers no stream beat and ignores register writes.
- R10: Hardware reset clears every register to 0. A soft reset clears the request bit and the engine state, but keeps the transmit list base (index 2) and the receive list base (index 3).
- R11: A soft reset issued in the middle of a frame may cut the stream short without `tx_last`. Afterwards the engine stays idle, and a new request starts again at the list base.
- R12: If a write of 1 to the request bit lands in the same cycle as the engine's own clear on an unowned descriptor, the clear wins. The request bit reads 0 and the engine stays idle.
- R13: The engine holds `mem_req` high, with `mem_addr`, `mem_we` and `mem_wdata` unchanged, until the memory answers with `mem_ack`. Read data is taken from `mem_rdata` in the cycle in which `mem_ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 2 | Register index: 0 control, 1 request, 2 transmit base, 3 receive base |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for the register at `reg_idx` (combinational) |
| srst_busy | output | 1 | High during the soft-reset window |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for a write (descriptor write-back), 0 for a read |
| mem_addr | output | 32 | Byte address of the memory word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Memory has completed the access this cycle |
| mem_rdata | input | 32 | Read data, valid while `mem_ack` is high |
| tx_valid | output | 1 | Stream beat offered |
| tx_ready | input | 1 | MAC accepts the beat |
| tx_data | output | 32 | Beat data, byte 0 in bits 7:0 |
| tx_keep | output | 4 | Byte enables, one bit per byte |
| tx_last | output | 1 | Final beat of the frame |

## Verification
Two events can meet in one clock edge: the software write that sets the request bit, and the engine's own clear when it reads an unowned descriptor. The bench waits until the memory acknowledge for the unowned descriptor is visible. It then presents the register write so that both take effect on the same edge. The result is judged at the ports: the request bit must read 0, and `mem_req` must stay low for the cycles that follow. The bench also checks a soft reset that lands in the middle of a frame, where back-pressure and the reset window overlap.

// File: rtl/txd_pkg.sv
package txd_pkg;
  localparam int unsigned BEAT_W = 32;
  localparam int unsigned BEAT_B = BEAT_W / 8;

  localparam logic [1:0] IDX_CTRL   = 2'd0;
  localparam logic [1:0] IDX_TXREQ  = 2'd1;
  localparam logic [1:0] IDX_TXBASE = 2'd2;
  localparam logic [1:0] IDX_RXBASE = 2'd3;

  localparam int unsigned OWN_BIT  = 31;
  localparam int unsigned WRAP_BIT = 30;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DESC0,
    ST_DESC1,
    ST_DATA_RD,
    ST_DATA_OUT,
    ST_RETIRE
  } walk_st_e;
endpackage

// File: rtl/txd_srst.sv
module txd_srst #(
  parameter int unsigned SRST_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  output logic busy
);
  localparam int unsigned CW = $clog2(SRST_CYCLES + 1);
  logic [CW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               left_q <= '0;
    else if (kick)            left_q <= CW'(SRST_CYCLES);
    else if (left_q != '0)    left_q <= left_q - 1'b1;
  end

  assign busy = (left_q != '0);
endmodule

// File: rtl/txd_regs.sv
module txd_regs
  import txd_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [1:0]        idx,
  input  logic [31:0]       wdata,
  input  logic              busy,
  input  logic              tr_clr,
  output logic [31:0]       rdata,
  output logic              tr,
  output logic              start,
  output logic              kick,
  output logic [ADDR_W-1:0] tx_base,
  output logic [ADDR_W-1:0] rx_base
);
  logic wr_ok;
  assign wr_ok = wr && !busy;
  assign kick  = wr_ok && (idx == IDX_CTRL) && wdata[0];
  assign start = wr_ok && (idx == IDX_TXREQ) && wdata[0] && !tr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tr <= 1'b0;
    end else if (kick || tr_clr) begin
      tr <= 1'b0;
    end else if (start) begin
      tr <= 1'b1;
    end
  end

  // list bases survive the soft reset: only the hardware reset clears them
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_base <= '0;
      rx_base <= '0;
    end else if (wr_ok) begin
      if (idx == IDX_TXBASE) tx_base <= wdata[ADDR_W-1:0];
      if (idx == IDX_RXBASE) rx_base <= wdata[ADDR_W-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    unique case (idx)
      IDX_CTRL:   rdata[0] = busy;
      IDX_TXREQ:  rdata[0] = tr;
      IDX_TXBASE: rdata[ADDR_W-1:0] = tx_base;
      default:    rdata[ADDR_W-1:0] = rx_base;
    endcase
  end
endmodule

// File: rtl/txd_lane.sv
module txd_lane
  import txd_pkg::*;
#(
  parameter int unsigned LEN_W = 16
) (
  input  logic [LEN_W-1:0]  rem,
  output logic [BEAT_B-1:0] keep,
  output logic              last
);
  for (genvar i = 0; i < BEAT_B; i++) begin : g_lane
    assign keep[i] = (rem > LEN_W'(i));
  end
  assign last = (rem <= LEN_W'(BEAT_B));
endmodule

// File: rtl/txd_walker.sv
module txd_walker
  import txd_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned LEN_W       = 16,
  parameter int unsigned DESC_STRIDE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              start,
  input  logic [ADDR_W-1:0] base,
  output logic              tr_clr,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BEAT_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [BEAT_W-1:0] mem_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [BEAT_W-1:0] tx_data,
  output logic [BEAT_B-1:0] tx_keep,
  output logic              tx_last
);
  localparam logic [ADDR_W-1:0] STEP  = ADDR_W'(DESC_STRIDE);
  localparam logic [ADDR_W-1:0] WORD1 = ADDR_W'(BEAT_B);
  localparam logic [LEN_W-1:0]  BEATB = LEN_W'(BEAT_B);

  walk_st_e          st_q;
  logic [ADDR_W-1:0] ptr_q, buf_q;
  logic [BEAT_W-1:0] w0_q, dat_q;
  logic [LEN_W-1:0]  rem_q;
  logic              fin_beat;

  txd_lane #(.LEN_W(LEN_W)) u_lane (
    .rem  (rem_q),
    .keep (tx_keep),
    .last (fin_beat)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      ptr_q <= '0;
      buf_q <= '0;
      w0_q  <= '0;
      dat_q <= '0;
      rem_q <= '0;
    end else if (flush) begin
      st_q  <= ST_IDLE;
      ptr_q <= base;
      rem_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start) begin
          ptr_q <= base;
          st_q  <= ST_DESC0;
        end
        ST_DESC0: if (mem_ack) begin
          w0_q  <= mem_rdata;
          rem_q <= mem_rdata[LEN_W-1:0];
          st_q  <= mem_rdata[OWN_BIT] ? ST_DESC1 : ST_IDLE;
        end
        ST_DESC1: if (mem_ack) begin
          buf_q <= {mem_rdata[ADDR_W-1:2], 2'b00};
          st_q  <= (rem_q == '0) ? ST_RETIRE : ST_DATA_RD;
        end
        ST_DATA_RD: if (mem_ack) begin
          dat_q <= mem_rdata;
          st_q  <= ST_DATA_OUT;
        end
        ST_DATA_OUT: if (tx_ready) begin
          if (fin_beat) begin
            rem_q <= '0;
            st_q  <= ST_RETIRE;
          end else begin
            rem_q <= rem_q - BEATB;
            buf_q <= buf_q + WORD1;
            st_q  <= ST_DATA_RD;
          end
        end
        ST_RETIRE: if (mem_ack) begin
          ptr_q <= w0_q[WRAP_BIT] ? base : ptr_q + STEP;
          st_q  <= ST_DESC0;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign tr_clr = (st_q == ST_DESC0) && mem_ack && !mem_rdata[OWN_BIT] && !flush;

  always_comb begin
    mem_req  = 1'b0;
    mem_addr = ptr_q;
    unique case (st_q)
      ST_DESC0:   mem_req = 1'b1;
      ST_DESC1: begin
        mem_req  = 1'b1;
        mem_addr = ptr_q + WORD1;
      end
      ST_DATA_RD: begin
        mem_req  = 1'b1;
        mem_addr = buf_q;
      end
      ST_RETIRE:  mem_req = 1'b1;
      default:    mem_req = 1'b0;
    endcase
  end

  assign mem_we    = (st_q == ST_RETIRE);
  assign mem_wdata = {1'b0, w0_q[BEAT_W-2:0]};
  assign tx_valid  = (st_q == ST_DATA_OUT);
  assign tx_data   = dat_q;
  assign tx_last   = tx_valid && fin_beat;
endmodule

// File: rtl/txd_engine.sv
module txd_engine
  import txd_pkg::*;
#(
  parameter int unsigned LEN_W       = 16,
  parameter int unsigned SRST_CYCLES = 16,
  parameter int unsigned DESC_STRIDE = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_idx,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        srst_busy,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [31:0] tx_data,
  output logic [3:0]  tx_keep,
  output logic        tx_last
);
  localparam int unsigned ADDR_W = 32;

  logic              tr_q, start, kick, tr_clr, flush;
  logic [ADDR_W-1:0] tx_base, rx_base;

  txd_srst #(.SRST_CYCLES(SRST_CYCLES)) u_srst (
    .clk   (clk),
    .rst_n (rst_n),
    .kick  (kick),
    .busy  (srst_busy)
  );

  txd_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (reg_wr),
    .idx     (reg_idx),
    .wdata   (reg_wdata),
    .busy    (srst_busy),
    .tr_clr  (tr_clr),
    .rdata   (reg_rdata),
    .tr      (tr_q),
    .start   (start),
    .kick    (kick),
    .tx_base (tx_base),
    .rx_base (rx_base)
  );

  assign flush = kick || srst_busy;

  txd_walker #(
    .ADDR_W      (ADDR_W),
    .LEN_W       (LEN_W),
    .DESC_STRIDE (DESC_STRIDE)
  ) u_walk (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .start     (start),
    .base      (tx_base),
    .tr_clr    (tr_clr),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .mem_rdata (mem_rdata),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_data   (tx_data),
    .tx_keep   (tx_keep),
    .tx_last   (tx_last)
  );
endmodule

// File: rtl/txd_engine_chk.sv
module txd_engine_chk #(
  parameter int unsigned SRST_CYCLES = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic        srst_busy,
  input logic        kick,
  input logic        tr_q,
  input logic        mem_req,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic        mem_ack,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic [31:0] tx_data,
  input logic [3:0]  tx_keep,
  input logic        tx_last
);
  localparam int unsigned RW = $clog2(SRST_CYCLES + 2);
  logic [RW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         run_q <= '0;
    else if (srst_busy) run_q <= (run_q == {RW{1'b1}}) ? run_q : run_q + 1'b1;
    else                run_q <= '0;
  end

  AST_STREAM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !kick) |=> (tx_valid && $stable(tx_data) && $stable(tx_keep) && $stable(tx_last))); // R7

  AST_KEEP_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (tx_keep != 4'd0) && (((tx_keep + 4'd1) & tx_keep) == 4'd0)); // R2

  AST_MID_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_last) |-> (tx_keep == 4'hF)); // R2

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !kick) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R13

  AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    srst_busy |-> (!mem_req && !tx_valid)); // R9

  AST_BUSY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(srst_busy) |-> (run_q == RW'(SRST_CYCLES))); // R9

  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !tr_q |-> (!mem_req && !tx_valid)); // R5

  AST_WB_NOT_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> !mem_wdata[31]); // R4
endmodule

bind txd_engine txd_engine_chk #(.SRST_CYCLES(SRST_CYCLES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .srst_busy (srst_busy),
  .kick      (kick),
  .tr_q      (tr_q),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_ack   (mem_ack),
  .tx_valid  (tx_valid),
  .tx_ready  (tx_ready),
  .tx_data   (tx_data),
  .tx_keep   (tx_keep),
  .tx_last   (tx_last)
);

// File: tb/tb_txd_engine.sv
module tb_txd_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_idx = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        srst_busy, mem_req, mem_we, tx_valid, tx_last;
  logic [31:0] mem_addr, mem_wdata, tx_data;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        tx_ready = 1'b1;
  logic [3:0]  tx_keep;

  always #10 clk = ~clk;

  txd_engine dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .srst_busy(srst_busy),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_keep(tx_keep), .tx_last(tx_last)
  );

  int total = 0;
  int bad = 0;

  // memory model: one-cycle acknowledge, read data valid with acknowledge
  logic [31:0] mem [0:127];
  logic        bw_en = 1'b0;
  logic [6:0]  bw_idx = '0;
  logic [31:0] bw_data = '0;
  logic        stall_en = 1'b0;
  logic [2:0]  rcnt = '0;

  always_ff @(posedge clk) begin
    if (!rst_n) mem_ack <= 1'b0;
    else        mem_ack <= mem_req && !mem_ack;
    if (mem_req) mem_rdata <= mem[mem_addr[8:2]];
    if (bw_en) mem[bw_idx] <= bw_data;
    else if (mem_req && mem_ack && mem_we) mem[mem_addr[8:2]] <= mem_wdata;
    rcnt     <= rcnt + 3'd1;
    tx_ready <= stall_en ? (rcnt[0] ^ rcnt[2]) : 1'b1;
  end

  // observation at the falling edge
  logic [31:0] bd [0:15];
  logic [3:0]  bk [0:15];
  logic        bl [0:15];
  int          nb = 0;
  int          busy_cyc = 0;
  int          busy_act = 0;
  logic        rd_seen = 1'b0;
  logic [31:0] first_rd = '0;

  always @(negedge clk) begin
    if (rst_n && tx_valid && tx_ready) begin
      if (nb < 16) begin
        bd[nb] = tx_data; bk[nb] = tx_keep; bl[nb] = tx_last;
      end
      nb = nb + 1;
    end
    if (srst_busy) begin
      busy_cyc = busy_cyc + 1;
      if (mem_req || tx_valid) busy_act = busy_act + 1;
    end
    if (!rd_seen && mem_req && !mem_we) begin
      rd_seen  = 1'b1;
      first_rd = mem_addr;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] idx, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_idx = idx; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] idx, output logic [31:0] d);
    reg_idx = idx;
    #1 d = reg_rdata;
  endtask

  task automatic poke(input int idx, input logic [31:0] d);
    @(negedge clk);
    bw_en = 1'b1; bw_idx = 7'(idx); bw_data = d;
    @(posedge clk);
    @(negedge clk);
    bw_en = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      rd(2'd1, v);
      if (v == 32'd0) break;
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int i = 0; i < 4; i++) begin
      rd(2'(i), v);
      chk(v == 32'd0, "R10 register clear after hardware reset", v, 32'd0);
    end
    chk(!tx_valid && !mem_req && !srst_busy, "R10 outputs quiet after reset",
        {29'd0, tx_valid, mem_req, srst_busy}, 32'd0);
  endtask

  task automatic t_reserved();
    logic [31:0] v;
    int reqs = 0;
    wr(2'd1, 32'hFFFF_FFFE);
    rd(2'd1, v);
    chk(v == 32'd0, "R8 reserved request bits", v, 32'd0);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (mem_req) reqs++;
    end
    chk(reqs == 0, "R8 no start from reserved bits", 32'(reqs), 32'd0);
  endtask

  task automatic t_frames();
    logic [31:0] v;
    logic [31:0] ed [0:4];
    logic [3:0]  ek [0:4];
    logic        el [0:4];
    poke(0, 32'h8000_0006);  poke(1, 32'h0000_0100);
    poke(4, 32'h8000_0000);  poke(5, 32'h0000_0120);
    poke(8, 32'hC000_0009);  poke(9, 32'h0000_0140);
    poke(12, 32'h8000_0004); poke(13, 32'h0000_0180);
    poke(64, 32'h4433_2211); poke(65, 32'h8877_6655);
    poke(80, 32'hA3A2_A1A0); poke(81, 32'hB3B2_B1B0); poke(82, 32'hC3C2_C1C0);
    poke(96, 32'hDEAD_BEEF);
    ed[0] = 32'h4433_2211; ek[0] = 4'hF; el[0] = 1'b0;
    ed[1] = 32'h8877_6655; ek[1] = 4'h3; el[1] = 1'b1;
    ed[2] = 32'hA3A2_A1A0; ek[2] = 4'hF; el[2] = 1'b0;
    ed[3] = 32'hB3B2_B1B0; ek[3] = 4'hF; el[3] = 1'b0;
    ed[4] = 32'hC3C2_C1C0; ek[4] = 4'h1; el[4] = 1'b1;
    stall_en = 1'b1;
    nb = 0; rd_seen = 1'b0;
    wr(2'd2, 32'h0000_0000);
    wr(2'd1, 32'h0000_0001);
    for (int i = 0; i < 500 && nb < 1; i++) @(negedge clk);
    wr(2'd1, 32'h0000_0000);
    rd(2'd1, v);
    chk(v == 32'd1, "R3 write 0 keeps request set", v, 32'd1);
    wr(2'd1, 32'h0000_0001);
    wait_idle();
    stall_en = 1'b0;
    chk(first_rd == 32'd0, "R1 first fetch at list base", first_rd, 32'd0);
    chk(nb == 5, "R2 R6 beat count", 32'(nb), 32'd5);
    for (int i = 0; i < 5; i++) begin
      chk(bd[i] == ed[i], "R7 beat data under back-pressure", bd[i], ed[i]);
      chk(bk[i] == ek[i], "R2 beat byte enables", {28'd0, bk[i]}, {28'd0, ek[i]});
      chk(bl[i] == el[i], "R2 last flag", {31'd0, bl[i]}, {31'd0, el[i]});
    end
    chk(mem[0] == 32'h0000_0006, "R4 write-back clears owner", mem[0], 32'h0000_0006);
    chk(mem[4] == 32'h0000_0000, "R6 empty descriptor returned", mem[4], 32'h0000_0000);
    chk(mem[8] == 32'h4000_0009, "R4 write-back keeps wrap and length", mem[8], 32'h4000_0009);
    chk(mem[12] == 32'h8000_0004, "R4 wrap skips next slot", mem[12], 32'h8000_0004);
    rd(2'd1, v);
    chk(v == 32'd0, "R5 unowned descriptor clears request", v, 32'd0);
  endtask

  task automatic t_srst();
    logic [31:0] v;
    int nb_at;
    poke(16, 32'h8000_0028); poke(17, 32'h0000_0100);
    wr(2'd3, 32'hABCD_0000);
    wr(2'd2, 32'h0000_0040);
    nb = 0; busy_cyc = 0; busy_act = 0;
    wr(2'd1, 32'h0000_0001);
    for (int i = 0; i < 500 && nb < 2; i++) @(negedge clk);
    wr(2'd0, 32'h0000_0001);
    rd(2'd0, v);
    chk(v == 32'd1, "R9 busy readable in control", v, 32'd1);
    wr(2'd2, 32'h0000_0077);
    for (int i = 0; i < 100 && srst_busy; i++) @(negedge clk);
    nb_at = nb;
    chk(busy_cyc == 16, "R9 soft reset window length", 32'(busy_cyc), 32'd16);
    chk(busy_act == 0, "R9 quiet during window", 32'(busy_act), 32'd0);
    rd(2'd2, v);
    chk(v == 32'h0000_0040, "R10 transmit base preserved", v, 32'h0000_0040);
    rd(2'd3, v);
    chk(v == 32'hABCD_0000, "R10 receive base preserved", v, 32'hABCD_0000);
    rd(2'd1, v);
    chk(v == 32'd0, "R10 request cleared by soft reset", v, 32'd0);
    chk(nb_at < 10, "R11 frame cut short", 32'(nb_at), 32'd10);
    repeat (6) @(negedge clk);
    chk(nb == nb_at && !mem_req, "R11 idle after soft reset", 32'(nb), 32'(nb_at));
    poke(16, 32'h0000_0000);
    rd_seen = 1'b0;
    wr(2'd1, 32'h0000_0001);
    wait_idle();
    chk(first_rd == 32'h0000_0040, "R11 restart at list base", first_rd, 32'h0000_0040);
  endtask

  task automatic t_race();
    logic [31:0] v;
    int reqs = 0;
    bit hit = 1'b0;
    wr(2'd1, 32'h0000_0001);
    for (int i = 0; i < 50; i++) begin
      if (mem_req && !mem_we && mem_ack && mem_addr == 32'h0000_0040) begin
        hit = 1'b1;
        break;
      end
      @(negedge clk);
    end
    reg_wr = 1'b1; reg_idx = 2'd1; reg_wdata = 32'h0000_0001;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
    chk(hit, "R12 collision cycle reached", {31'd0, hit}, 32'd1);
    rd(2'd1, v);
    chk(v == 32'd0, "R12 self-clear wins over write", v, 32'd0);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (mem_req) reqs++;
    end
    chk(reqs == 0, "R12 no fetch after collision", 32'(reqs), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog expired", 32'd0, 32'd1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_reserved();
    t_frames();
    t_srst();
    t_race();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule